// File: doc/BRIEF.md
# Coprocessor Bus Window Decoder

This block sits between a main CPU and a 32 KB window onto a coprocessor bus. It accepts one byte or word access at a time over a request/acknowledge handshake. It sorts each access by its address into one of four destinations: an external 8 KB local RAM, a four-register FM sound chip port, a one-bit bank register kept inside the block, and a reserved video page that stalls the CPU. Every other address in the upper quarter of the window is a harmless hole.

Every access to the coprocessor bus is one byte wide. A word write carries only its upper data byte. A word read fetches one byte and places it on both lanes. Writes to the local RAM are held back by a fixed number of wait cycles. An access to the reserved video page never completes unless a force-acknowledge configuration input is set. Without that input, the block raises a sticky halt output and keeps it raised until reset. With that input set, the block acknowledges the access, and a read returns the matching byte of the last prefetched instruction word.

Top module: `cobus_window`

## Requirements
- R1: Address bits 14:13 pick the target. The values 0 and 1 select the local RAM, with `ram_addr_o` equal to address bits 12:0. The value 2 selects the FM port. The value 3 selects the miscellaneous region, which raises no strobe.
- R2: An FM access puts address bits 1:0 on `fm_port_o`, and a read returns `fm_rdata_i`.
- R3: A write to the miscellaneous page where address bits 14:8 equal 0x60 loads the written byte's bit 0 into `bank_o`. `bank_o` changes on no other access.
- R4: With `force_ack_i` low, any access where address bits 14:8 equal 0x7F is never acknowledged and raises no strobe. From the cycle after acceptance, `halt_o` is high and stays high until reset.
- R5: With `force_ack_i` high, an access to page 0x7F is acknowledged like any other access. A read returns `prefetch_i[15:8]` when address bit 0 is 0 and `prefetch_i[7:0]` when it is 1. A write to that page changes nothing.
- R6: A read from any other miscellaneous page returns the byte 0xFF. A write there is acknowledged and leaves `bank_o` unchanged.
- R7: A word read (`word_i`=1) returns the fetched byte on both `rdata_o[15:8]` and `rdata_o[7:0]`. A byte read returns it on `rdata_o[7:0]` with bits 15:8 set to zero.
- R8: A word write delivers `wdata_i[15:8]` as a single byte. A byte write delivers `wdata_i[7:0]`.
- R9: `ack_o` rises in the third cycle after the clock edge that accepts a request. A local RAM write is acknowledged exactly 8 cycles later than that.
- R10: `ack_o` is a one-cycle pulse. Each RAM or FM access raises exactly one one-cycle strobe, and the RAM and FM strobes are never high together.
- R11: After reset, `ack_o`, `halt_o`, `bank_o` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| force_ack_i | input | 1 | Complete accesses to the stalling page instead of halting |
| req_i | input | 1 | Access request, held until `ack_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = word access, 0 = byte access |
| addr_i | input | 15 | Byte address inside the window |
| wdata_i | input | 16 | Write data (byte writes on bits 7:0) |
| prefetch_i | input | 16 | Last prefetched instruction word (open-bus source) |
| ack_o | output | 1 | One-cycle access acknowledge |
| rdata_o | output | 16 | Read data, valid with `ack_o` |
| halt_o | output | 1 | Sticky lock-up indication |
| ram_cs_o | output | 1 | Local RAM strobe |
| ram_we_o | output | 1 | Local RAM write enable |
| ram_addr_o | output | 13 | Local RAM byte index |
| ram_wdata_o | output | 8 | Local RAM write byte |
| ram_rdata_i | input | 8 | Local RAM read byte, valid the cycle after the strobe |
| fm_cs_o | output | 1 | FM port strobe |
| fm_we_o | output | 1 | FM port write enable |
| fm_port_o | output | 2 | FM register port index |
| fm_wdata_o | output | 8 | FM write byte |
| fm_rdata_i | input | 8 | FM read byte, valid the cycle after the strobe |
| bank_o | output | 1 | Bank register bit |

## Verification
In one accept cycle, the page decode can choose the bank page or the stalling page while `force_ack_i` decides whether an illegal access halts or completes. The bench sweeps every target with byte and word accesses, reads and writes, for both settings of `force_ack_i`. It judges the halt path by the missing acknowledge and strobes, and it judges the forced path by the prefetch byte and an unchanged bank bit. The RAM write wait and the acknowledge timing also share the final state sequence. The bench measures latency in cycles for every access and expects the RAM write latency to be exactly 8 cycles more than the others.

// File: rtl/cobus_pkg.sv
// Shared types for the coprocessor bus window decoder.
// Assumes: one access in flight at a time.
package cobus_pkg;

    typedef enum logic [2:0] {
        TGT_RAM  = 3'd0,
        TGT_FM   = 3'd1,
        TGT_BANK = 3'd2,
        TGT_HOLE = 3'd3,
        TGT_LOCK = 3'd4
    } cobus_tgt_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_STROBE = 3'd1,
        ST_WAIT   = 3'd2,
        ST_RESP   = 3'd3,
        ST_ACK    = 3'd4,
        ST_LOCK   = 3'd5
    } cobus_st_e;

endpackage

// File: rtl/cobus_decode.sv
// Page decoder: maps the address bits above the byte offset to a target.
// Assumes: the top two bits of page_i are the region selector.
module cobus_decode
    import cobus_pkg::*;
#(
    parameter int PAGE_W    = 7,
    parameter int BANK_PAGE = 96,
    parameter int LOCK_PAGE = 127
) (
    input  logic [PAGE_W-1:0] page_i,
    output cobus_tgt_e        tgt_o
);
    localparam logic [PAGE_W-1:0] BANK_P = PAGE_W'(BANK_PAGE);
    localparam logic [PAGE_W-1:0] LOCK_P = PAGE_W'(LOCK_PAGE);

    logic [1:0] region;
    assign region = page_i[PAGE_W-1 -: 2];

    // Region first, then the page compare inside the miscellaneous quarter.
    always_comb begin
        unique case (region)
            2'b10:   tgt_o = TGT_FM;
            2'b11: begin
                if (page_i == LOCK_P)      tgt_o = TGT_LOCK;
                else if (page_i == BANK_P) tgt_o = TGT_BANK;
                else                       tgt_o = TGT_HOLE;
            end
            default: tgt_o = TGT_RAM;
        endcase
    end
endmodule

// File: rtl/cobus_lane.sv
// Byte-lane narrowing: picks the write byte and spreads the read byte.
// Assumes: byte writes carry data on bits 7:0.
module cobus_lane #(
    parameter int DW = 16
) (
    input  logic          word_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [7:0]    rbyte_i,
    output logic [7:0]    wbyte_o,
    output logic [DW-1:0] rdata_o
);
    localparam int LANES = DW / 8;

    // Word writes keep only the upper byte.
    assign wbyte_o = word_i ? wdata_i[DW-1 -: 8] : wdata_i[7:0];

    // Word reads mirror the byte on every lane; byte reads use lane 0 only.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign rdata_o[7:0] = rbyte_i;
        end else begin : g_high
            assign rdata_o[g*8 +: 8] = word_i ? rbyte_i : 8'h00;
        end
    end
endmodule

// File: rtl/cobus_wait.sv
// Wait counter: after load_i, done_o rises once WAIT_CYC cycles have passed.
// Assumes: WAIT_CYC >= 1; done_o is consulted only while waiting.
module cobus_wait #(
    parameter int WAIT_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic done_o
);
    localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CW-1:0] LOAD_V = CW'(WAIT_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Count down from the load value to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load_i)     cnt_q <= LOAD_V;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/cobus_window.sv
// Coprocessor bus window decoder: one byte-wide access at a time into a
// RAM, an FM port, a bank bit, a hole region, or a stalling page.
// Assumes: the requester holds req_i until ack_o and drops it in the
// ack cycle; the RAM and FM read bytes are valid the cycle after a strobe.
module cobus_window
    import cobus_pkg::*;
#(
    parameter int RAM_AW    = 13,
    parameter int WAIT_CYC  = 8,
    parameter int PORT_W    = 2,
    parameter int BANK_PAGE = 96,
    parameter int LOCK_PAGE = 127
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     force_ack_i,
    input  logic                     req_i,
    input  logic                     we_i,
    input  logic                     word_i,
    input  logic [RAM_AW+1:0]        addr_i,
    input  logic [15:0]              wdata_i,
    input  logic [15:0]              prefetch_i,
    output logic                     ack_o,
    output logic [15:0]              rdata_o,
    output logic                     halt_o,
    output logic                     ram_cs_o,
    output logic                     ram_we_o,
    output logic [RAM_AW-1:0]        ram_addr_o,
    output logic [7:0]               ram_wdata_o,
    input  logic [7:0]               ram_rdata_i,
    output logic                     fm_cs_o,
    output logic                     fm_we_o,
    output logic [PORT_W-1:0]        fm_port_o,
    output logic [7:0]               fm_wdata_o,
    input  logic [7:0]               fm_rdata_i,
    output logic                     bank_o
);
    localparam int ADDR_W = RAM_AW + 2;
    localparam int PAGE_W = ADDR_W - 8;

    cobus_st_e         st_q;
    cobus_tgt_e        tgt_d, tgt_q;
    logic              we_q, word_q, bank_q, halt_q;
    logic [RAM_AW-1:0] addr_q;
    logic [7:0]        wbyte_d, wbyte_q, rbyte_q;
    logic              wait_load, wait_done;

    cobus_decode #(
        .PAGE_W   (PAGE_W),
        .BANK_PAGE(BANK_PAGE),
        .LOCK_PAGE(LOCK_PAGE)
    ) i_decode (
        .page_i(addr_i[ADDR_W-1:8]),
        .tgt_o (tgt_d)
    );

    cobus_lane #(.DW(16)) i_lane (
        .word_i (word_i),
        .wdata_i(wdata_i),
        .rbyte_i(rbyte_q),
        .wbyte_o(wbyte_d),
        .rdata_o(rdata_o)
    );

    cobus_wait #(.WAIT_CYC(WAIT_CYC)) i_wait (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(wait_load),
        .done_o(wait_done)
    );

    assign wait_load = (st_q == ST_STROBE) && (tgt_q == TGT_RAM) && we_q;

    // Access sequencer: accept, strobe, optional wait, response, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            tgt_q   <= TGT_HOLE;
            we_q    <= 1'b0;
            word_q  <= 1'b0;
            addr_q  <= '0;
            wbyte_q <= '0;
            halt_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (req_i) begin
                    tgt_q   <= tgt_d;
                    we_q    <= we_i;
                    word_q  <= word_i;
                    addr_q  <= addr_i[RAM_AW-1:0];
                    wbyte_q <= wbyte_d;
                    if (tgt_d == TGT_LOCK && !force_ack_i) begin
                        st_q   <= ST_LOCK;
                        halt_q <= 1'b1;
                    end else begin
                        st_q <= ST_STROBE;
                    end
                end
                ST_STROBE: st_q <= wait_load ? ST_WAIT : ST_RESP;
                ST_WAIT:   if (wait_done) st_q <= ST_RESP;
                ST_RESP:   st_q <= ST_ACK;
                ST_ACK:    st_q <= ST_IDLE;
                ST_LOCK:   st_q <= ST_LOCK;
                default:   st_q <= ST_IDLE;
            endcase
        end
    end

    // Read byte capture in the cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbyte_q <= '0;
        end else if (st_q == ST_RESP) begin
            unique case (tgt_q)
                TGT_RAM:  rbyte_q <= ram_rdata_i;
                TGT_FM:   rbyte_q <= fm_rdata_i;
                TGT_LOCK: rbyte_q <= addr_q[0] ? prefetch_i[7:0] : prefetch_i[15:8];
                default:  rbyte_q <= 8'hFF;
            endcase
        end
    end

    // Bank bit update on a write to the bank page.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= 1'b0;
        else if (st_q == ST_STROBE && tgt_q == TGT_BANK && we_q)
            bank_q <= wbyte_q[0];
    end

    assign ram_cs_o    = (st_q == ST_STROBE) && (tgt_q == TGT_RAM);
    assign ram_we_o    = ram_cs_o && we_q;
    assign ram_addr_o  = addr_q;
    assign ram_wdata_o = wbyte_q;
    assign fm_cs_o     = (st_q == ST_STROBE) && (tgt_q == TGT_FM);
    assign fm_we_o     = fm_cs_o && we_q;
    assign fm_port_o   = addr_q[PORT_W-1:0];
    assign fm_wdata_o  = wbyte_q;
    assign ack_o       = (st_q == ST_ACK);
    assign halt_o      = halt_q;
    assign bank_o      = bank_q;

    // R4: a halted bus never acknowledges.
    assert_halt_blocks_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> !ack_o);
    // R4: the halt indication holds until reset.
    assert_halt_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);
    // R10: the acknowledge is a single-cycle pulse.
    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);
    // R10: never two target strobes at once, and each lasts one cycle.
    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_cs_o, fm_cs_o}));
    assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_cs_o || fm_cs_o) |=> !(ram_cs_o || fm_cs_o));
    // R3: the bank bit moves only after a bank-page write strobe.
    assert_bank_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q == ST_STROBE && tgt_q == TGT_BANK && we_q) |=> $stable(bank_o));
    // R7: word reads deliver identical lanes.
    assert_word_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && word_q && !we_q) |-> (rdata_o[15:8] == rdata_o[7:0]));
endmodule

// File: tb/test_cobus_window.sv
`timescale 1ns/1ps
// Sweep bench for cobus_window: all regions, sizes, directions, force modes.
module test_cobus_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        force_ack_i = 1'b0;
    logic        req_i = 1'b0, we_i = 1'b0, word_i = 1'b0;
    logic [14:0] addr_i = '0;
    logic [15:0] wdata_i = '0, prefetch_i = 16'h4E71;
    logic        ack_o, halt_o, ram_cs_o, ram_we_o, fm_cs_o, fm_we_o, bank_o;
    logic [15:0] rdata_o;
    logic [12:0] ram_addr_o;
    logic [7:0]  ram_wdata_o, fm_wdata_o;
    logic [7:0]  ram_rdata_i = '0, fm_rdata_i = '0;
    logic [1:0]  fm_port_o;

    int n_chk = 0, n_err = 0, n_stb = 0;
    logic [12:0] last_ra;
    logic [7:0]  last_rd, last_fd;
    logic [1:0]  last_fp;

    always #2 clk = ~clk;

    cobus_window i_cobus_window (
        .clk(clk), .rst_n(rst_n), .force_ack_i(force_ack_i), .req_i(req_i),
        .we_i(we_i), .word_i(word_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .prefetch_i(prefetch_i), .ack_o(ack_o), .rdata_o(rdata_o), .halt_o(halt_o),
        .ram_cs_o(ram_cs_o), .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o),
        .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i), .fm_cs_o(fm_cs_o),
        .fm_we_o(fm_we_o), .fm_port_o(fm_port_o), .fm_wdata_o(fm_wdata_o),
        .fm_rdata_i(fm_rdata_i), .bank_o(bank_o)
    );

    function automatic logic [7:0] ram_val(input logic [12:0] a);
        return a[7:0] ^ {a[12:8], 3'b101};
    endfunction
    function automatic logic [7:0] fm_val(input logic [1:0] p);
        return 8'h90 + {6'h0, p};
    endfunction

    // Target models: synchronous read byte, write capture, strobe count.
    always @(posedge clk) begin
        if (ram_cs_o) begin
            n_stb <= n_stb + 1;
            ram_rdata_i <= ram_val(ram_addr_o);
            if (ram_we_o) begin last_ra <= ram_addr_o; last_rd <= ram_wdata_o; end
        end
        if (fm_cs_o) begin
            n_stb <= n_stb + 1;
            fm_rdata_i <= fm_val(fm_port_o);
            if (fm_we_o) begin last_fp <= fm_port_o; last_fd <= fm_wdata_o; end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; req_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic access(input bit we, input bit wd, input logic [14:0] a,
                          input logic [15:0] d, output logic [15:0] rd,
                          output int lat, output bit acked);
        @(negedge clk);
        req_i = 1'b1; we_i = we; word_i = wd; addr_i = a; wdata_i = d;
        acked = 1'b0; lat = 0; rd = '0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (ack_o) begin
                acked = 1'b1; lat = k; rd = rdata_o; req_i = 1'b0;
                break;
            end
        end
        req_i = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int lat, stb0;
        bit acked, exp_bank;
        do_reset();
        @(negedge clk);
        // R11: reset state
        check(!ack_o && !halt_o && !bank_o && !ram_cs_o && !fm_cs_o,
              "R11 reset state", {ack_o, halt_o, bank_o, ram_cs_o, fm_cs_o}, 0);
        exp_bank = 1'b0;

        for (int fa = 0; fa < 2; fa++) begin
            force_ack_i = fa[0];
            for (int r = 0; r < 4; r++) begin
                for (int j = 0; j < 6; j++) begin
                    for (int wd = 0; wd < 2; wd++) begin
                        for (int we = 0; we < 2; we++) begin
                            logic [14:0] a;
                            logic [15:0] d;
                            logic [4:0]  sub;
                            logic [7:0]  wb, eb;
                            bit lock, is_ram, is_fm;
                            int sel;
                            sel = (j + wd + we) % 6;
                            case (sel)
                                0: sub = 5'd0;  1: sub = 5'd31; 2: sub = 5'd1;
                                3: sub = 5'd5;  4: sub = 5'd16; default: sub = 5'd30;
                            endcase
                            a[14:13] = r[1:0];
                            if (r == 3) a[12:8] = sub;
                            else        a[12:8] = 5'(j * 7 + wd);
                            a[7:0] = 8'(j * 37 + wd * 3 + we);
                            d = 16'hA5C3 ^ 16'(j * 16'h1111 + we * 16'h0101 + wd * 16'h0100);
                            prefetch_i = 16'h4E00 | 16'(j * 5 + r);
                            wb = wd ? d[15:8] : d[7:0];
                            is_ram = (r < 2);
                            is_fm = (r == 2);
                            lock = (r == 3) && (a[14:8] == 7'h7F);
                            stb0 = n_stb;
                            access(we[0], wd[0], a, d, rd, lat, acked);
                            if (lock && !force_ack_i) begin
                                check(!acked, "R4 no ack on stall page", {31'd0, acked}, 0);
                                check(halt_o, "R4 halt raised", {31'd0, halt_o}, 1);
                                repeat (10) @(negedge clk);
                                check(halt_o && !ack_o, "R4 halt sticky", {30'd0, halt_o, ack_o}, 2);
                                check(n_stb == stb0, "R4 no strobe", n_stb - stb0, 0);
                                do_reset();
                                @(negedge clk);
                                check(!halt_o && !bank_o, "R11 halt and bank cleared",
                                      {30'd0, halt_o, bank_o}, 0);
                                exp_bank = 1'b0;
                                continue;
                            end
                            check(acked, "R9 access acknowledged", {31'd0, acked}, 1);
                            check(lat == ((is_ram && we) ? 11 : 3), "R9 latency",
                                  lat, (is_ram && we) ? 11 : 3);
                            check(n_stb - stb0 == ((is_ram || is_fm) ? 1 : 0),
                                  "R10 strobe count", n_stb - stb0, (is_ram || is_fm) ? 1 : 0);
                            if (we) begin
                                if (is_ram) begin
                                    check(last_ra == a[12:0], "R1 ram write index", last_ra, a[12:0]);
                                    check(last_rd == wb, "R8 ram write byte", last_rd, wb);
                                end
                                if (is_fm) begin
                                    check(last_fp == a[1:0], "R2 fm port", last_fp, a[1:0]);
                                    check(last_fd == wb, "R8 fm write byte", last_fd, wb);
                                end
                                if (r == 3 && a[14:8] == 7'h60) exp_bank = wb[0];
                                check(bank_o == exp_bank, lock ? "R5 bank after forced write"
                                      : (a[14:8] == 7'h60 ? "R3 bank write" : "R6 bank kept"),
                                      bank_o, exp_bank);
                            end else begin
                                if (is_ram)     eb = ram_val(a[12:0]);
                                else if (is_fm) eb = fm_val(a[1:0]);
                                else if (lock)  eb = a[0] ? prefetch_i[7:0] : prefetch_i[15:8];
                                else            eb = 8'hFF;
                                check(rd == (wd ? {eb, eb} : {8'h00, eb}),
                                      is_ram ? "R1 R7 ram read" : is_fm ? "R2 R7 fm read"
                                      : lock ? "R5 R7 forced read" : "R6 R7 hole read",
                                      rd, wd ? {eb, eb} : {8'h00, eb});
                                check(bank_o == exp_bank, "R3 bank unchanged by read", bank_o, exp_bank);
                            end
                        end
                    end
                end
            end
        end
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule